// File: doc/BRIEF.md
# Serial Bank-Addressed Segment Display Loader

The block takes display contents from a host over a slow three-wire serial link (a select line, a shift clock and a data line) plus a fourth pin that marks each bit as either a command bit or a display bit. Command bits fill a 4-bit mode word. The mode word picks one of four 50-bit segment banks or all banks chained as one 200-bit stream. It can also order a full clear. Display bits shift into the chosen bank. The 200-bit output image changes only when the select line falls, so a partial transfer never shows on the panel.

All four serial pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the edges of the select line and the shift clock are detected in the system clock domain. The host may send a mode word and display bits within one select window, or in separate windows. A bank selected in an earlier window stays selected for later display-only windows.

Top module: `seg_loader`

## Requirements
- R1: A serial bit is taken only on a rising shift-clock edge while the select line is high. Shift-clock edges while select is low change no bank content.
- R2: Command bits (mode pin high) shift into the 4-bit mode word from its LSB end, so the first of four bits lands in bit 3. With fewer than four bits, the older low bits move up. With more than four, only the last four remain.
- R3: Mode words 1000, 0100, 1100 and 0010 (bit 3 first) select bank 0, 1, 2 and 3. Bank k drives output bits 50k to 50k+49.
- R4: Mode word 1010 selects all banks as one 200-bit chain. After 200 display bits the first bit sits at output bit 0 and the last at output bit 199.
- R5: Mode word 1111 zeroes every bank and the output image at the select fall. The current selection is kept.
- R6: The output image copies the banks only on a falling select edge. A new mode word takes effect for display bits that follow it in the same window, and it is stored as the selection at the select fall.
- R7: A display bit enters the top of the selected range, and the range shifts one place toward its lowest index. With k<50 bits, the old bits at indices k..49 move down to 0..49-k. With more than 50 bits, only the last 50 remain.
- R8: After a full 50-bit burst the first bit maps to the lowest output bit of the bank. An output bit of 1 means the segment is on.
- R9: After reset no bank is selected, and the mode word, the banks and the output image are zero.
- R10: Display bits are discarded while no bank is selected. Any mode word outside the six codes above deselects all banks at the select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Serial select, asynchronous; its fall commits the transfer |
| sck_i | input | 1 | Serial shift clock, asynchronous |
| sdi_i | input | 1 | Serial data bit, asynchronous |
| msel_i | input | 1 | High marks a command bit, low a display bit |
| disp_o | output | 200 | Segment image, 1 = segment on |

## Verification
The hardest case is a partial burst: a mode word or a display burst that stops short, or runs long, when the select line falls. Its result depends on old content, which never reaches the pins until a later commit. The bench first fills the banks with known patterns. It then sends 2-bit and 6-bit mode words and 20-bit and 60-bit display bursts. It compares the full 200-bit image against a behavioural model on every clock. The model predicts the three-cycle commit delay after the select fall.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

    localparam int NUM_BANKS = 4;
    localparam int MODE_W    = 4;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_B0   = 3'd1,
        SEL_B1   = 3'd2,
        SEL_B2   = 3'd3,
        SEL_B3   = 3'd4,
        SEL_ALL  = 3'd5
    } sel_e;

    localparam logic [MODE_W-1:0] CODE_B0  = 4'b1000;
    localparam logic [MODE_W-1:0] CODE_B1  = 4'b0100;
    localparam logic [MODE_W-1:0] CODE_B2  = 4'b1100;
    localparam logic [MODE_W-1:0] CODE_B3  = 4'b0010;
    localparam logic [MODE_W-1:0] CODE_ALL = 4'b1010;
    localparam logic [MODE_W-1:0] CODE_CLR = 4'b1111;

    function automatic sel_e decode_mode(input logic [MODE_W-1:0] code);
        case (code)
            CODE_B0:  return SEL_B0;
            CODE_B1:  return SEL_B1;
            CODE_B2:  return SEL_B2;
            CODE_B3:  return SEL_B3;
            CODE_ALL: return SEL_ALL;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/seg_loader_sync.sv
module seg_loader_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.s3;
    assign fall_o = ~st_q.s2 & st_q.s3;

    // R1: an edge pulse lasts exactly one cycle
    p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/seg_loader_mode.sv
module seg_loader_mode
    import seg_loader_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_rise_i,
    input  logic cs_fall_i,
    input  logic mode_stb_i,
    input  logic sdi_i,
    output sel_e eff_sel_o,
    output logic clr_o
);
    typedef struct packed {
        logic [MODE_W-1:0] sh;
        logic              got;
        sel_e              sel;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_rise_i) st_d.got = 1'b0;
        if (mode_stb_i) begin
            st_d.sh  = {st_q.sh[MODE_W-2:0], sdi_i};
            st_d.got = 1'b1;
        end
        if (cs_fall_i && st_q.got && st_q.sh != CODE_CLR)
            st_d.sel = decode_mode(st_q.sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.got <= 1'b0;
            st_q.sel <= SEL_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_sel_o = st_q.got ? decode_mode(st_q.sh) : st_q.sel;
    assign clr_o     = cs_fall_i && st_q.got && (st_q.sh == CODE_CLR);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_stb_i |=> $stable(st_q.sh));

    p_sel_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall_i |=> $stable(st_q.sel));

    p_clear_keeps_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> $stable(st_q.sel));

endmodule

// File: rtl/seg_loader_banks.sv
module seg_loader_banks
    import seg_loader_pkg::*;
#(
    parameter int BANK_W = 50,
    localparam int TOTAL = BANK_W * NUM_BANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_stb_i,
    input  logic             sdi_i,
    input  sel_e             sel_i,
    input  logic             clr_i,
    input  logic             cs_fall_i,
    output logic [TOTAL-1:0] image_o
);
    typedef struct packed {
        logic [TOTAL-1:0] chain;
        logic [TOTAL-1:0] image;
    } st_t;

    st_t st_d, st_q;
    logic [TOTAL-1:0]     shifted;
    logic [NUM_BANKS-1:0] we;
    logic [NUM_BANKS-1:0] in_bit;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam int LO = k * BANK_W;
        assign we[k] = data_stb_i && (sel_i == SEL_ALL || sel_i == sel_e'(3'(k + 1)));
        if (k == NUM_BANKS - 1) begin : g_top
            assign in_bit[k] = sdi_i;
        end else begin : g_mid
            assign in_bit[k] = (sel_i == SEL_ALL) ? st_q.chain[LO + BANK_W] : sdi_i;
        end
        assign shifted[LO +: BANK_W] = we[k]
            ? {in_bit[k], st_q.chain[LO + 1 +: BANK_W - 1]}
            : st_q.chain[LO +: BANK_W];
    end

    always_comb begin
        st_d       = st_q;
        st_d.chain = clr_i ? '0 : shifted;
        if (cs_fall_i) st_d.image = clr_i ? '0 : st_q.chain;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign image_o = st_q.image;

    p_chain_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_stb_i && !clr_i) |=> $stable(st_q.chain));

    p_image_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall_i |=> $stable(st_q.image));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.image == '0 && st_q.chain == '0));

    p_single_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != SEL_ALL) |-> $onehot0(we));

    p_none_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SEL_NONE) |-> (we == '0));

endmodule

// File: rtl/seg_loader.sv
module seg_loader
    import seg_loader_pkg::*;
#(
    parameter int BANK_W = 50,
    localparam int TOTAL = BANK_W * NUM_BANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_i,
    input  logic             sck_i,
    input  logic             sdi_i,
    input  logic             msel_i,
    output logic [TOTAL-1:0] disp_o
);
    localparam int PIN_CS = 0, PIN_SCK = 1, PIN_SDI = 2, PIN_MSEL = 3;

    logic [3:0] lvl, rise, fall;
    logic       bit_stb, mode_stb, data_stb, clr;
    sel_e       eff_sel;
    logic       unused_edges;

    seg_loader_sync #(.W(4)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({msel_i, sdi_i, sck_i, cs_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign unused_edges = ^{fall[PIN_SCK], rise[PIN_SDI], fall[PIN_SDI],
                            rise[PIN_MSEL], fall[PIN_MSEL]};

    assign bit_stb  = rise[PIN_SCK] && lvl[PIN_CS];
    assign mode_stb = bit_stb && lvl[PIN_MSEL];
    assign data_stb = bit_stb && !lvl[PIN_MSEL];

    seg_loader_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_rise_i  (rise[PIN_CS]),
        .cs_fall_i  (fall[PIN_CS]),
        .mode_stb_i (mode_stb),
        .sdi_i      (lvl[PIN_SDI]),
        .eff_sel_o  (eff_sel),
        .clr_o      (clr)
    );

    seg_loader_banks #(.BANK_W(BANK_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_stb_i (data_stb),
        .sdi_i      (lvl[PIN_SDI]),
        .sel_i      (eff_sel),
        .clr_i      (clr),
        .cs_fall_i  (fall[PIN_CS]),
        .image_o    (disp_o)
    );

    p_reset_image_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> (disp_o == '0));

    p_no_strobe_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl[PIN_CS] |-> !bit_stb);

endmodule

// File: tb/seg_loader_test.sv
module seg_loader_test;
    localparam int BW  = 50;
    localparam int NB  = 4;
    localparam int TOT = BW * NB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, msel = 1'b0;
    logic [TOT-1:0] disp;

    always #5 clk = ~clk;

    seg_loader #(.BANK_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck),
        .sdi_i(sdi), .msel_i(msel), .disp_o(disp)
    );

    int n_run = 0, n_fail = 0;
    int clk_run = 0, clk_fail = 0;

    // behavioural model: -1 none, 0..3 one bank, 4 all banks
    logic       mdl_bank [TOT];
    int         mdl_sel = -1;
    logic [3:0] mdl_mode = 4'b0000;
    bit         mdl_got = 1'b0;
    logic [TOT-1:0] pend_val = '0;
    logic [TOT-1:0] exp_disp = '0;
    logic [2:0]     cs_dly = 3'b000;

    // the image follows the select fall by three clock edges
    always @(posedge clk) begin
        if (rst_n && !cs_dly[1] && cs_dly[2]) exp_disp <= pend_val;
        cs_dly <= rst_n ? {cs_dly[1:0], cs} : 3'b000;
    end

    // R6: image compared against the model on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            clk_run++;
            if (disp !== exp_disp) begin
                clk_fail++;
                $display("FAIL R6 per-clock image: got %h expected %h", disp, exp_disp);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + clk_run + 1, n_fail + clk_fail + 1);
        $finish;
    end

    function automatic int dec(input logic [3:0] c);
        case (c)
            4'b1000: return 0;
            4'b0100: return 1;
            4'b1100: return 2;
            4'b0010: return 3;
            4'b1010: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [TOT-1:0] pack();
        logic [TOT-1:0] v;
        for (int i = 0; i < TOT; i++) v[i] = mdl_bank[i];
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [TOT-1:0] exp);
        n_run++;
        if (disp !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, disp, exp);
        end
    endtask

    task automatic chk_bit(input string req, input int idx, input logic exp);
        n_run++;
        if (disp[idx] !== exp) begin
            n_fail++;
            $display("FAIL %s: bit %0d got %b expected %b", req, idx, disp[idx], exp);
        end
    endtask

    task automatic model_shift(input int s, input logic b);
        if (s >= 0 && s < NB) begin
            for (int i = 0; i < BW - 1; i++) mdl_bank[s*BW+i] = mdl_bank[s*BW+i+1];
            mdl_bank[s*BW+BW-1] = b;
        end else if (s == 4) begin
            for (int i = 0; i < TOT - 1; i++) mdl_bank[i] = mdl_bank[i+1];
            mdl_bank[TOT-1] = b;
        end
    endtask

    task automatic put_bit(input logic m, input logic b);
        msel = m; sdi = b;
        tick(3);
        sck = 1'b1;
        if (cs) begin
            if (m) begin
                mdl_mode = {mdl_mode[2:0], b};
                mdl_got  = 1'b1;
            end else begin
                model_shift(mdl_got ? dec(mdl_mode) : mdl_sel, b);
            end
        end
        tick(4);
        sck = 1'b0;
        tick(3);
    endtask

    task automatic open_win();
        cs = 1'b1; mdl_got = 1'b0;
        tick(4);
    endtask

    task automatic close_win();
        cs = 1'b0;
        if (mdl_got) begin
            if (mdl_mode == 4'b1111) begin
                for (int i = 0; i < TOT; i++) mdl_bank[i] = 1'b0;
            end else begin
                mdl_sel = dec(mdl_mode);
            end
        end
        pend_val = pack();
        tick(6);
    endtask

    task automatic send_mode(input logic [3:0] c);
        for (int i = 3; i >= 0; i--) put_bit(1'b1, c[i]);
    endtask

    task automatic send_data(input int n, input int seed);
        for (int i = 0; i < n; i++) put_bit(1'b0, ((i * 7 + seed) % 3) == 0);
    endtask

    initial begin
        for (int i = 0; i < TOT; i++) mdl_bank[i] = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R9 reset image zero", '0);

        // R10: display bits with nothing selected are dropped
        open_win(); send_data(50, 1); close_win();
        chk("R10 no selection ignores data", '0);

        // R3 R8: bank 0, single marker bit first
        open_win(); send_mode(4'b1000); put_bit(1'b0, 1'b1); send_data(49, 2); close_win();
        chk("R3 bank0 write", pack());
        chk_bit("R8 first bit at lowest index, 1=on", 0, 1'b1);

        // R6: selection persists, mode and data in separate windows
        open_win(); send_mode(4'b0100); close_win();
        chk("R6 mode-only window leaves image", pack());
        open_win(); send_data(50, 0); close_win();
        chk("R3 bank1 write", pack());

        open_win(); send_mode(4'b1100); send_data(50, 2); close_win();
        chk("R3 bank2 write", pack());
        open_win(); send_mode(4'b0010); send_data(50, 1); close_win();
        chk("R3 bank3 write", pack());

        // R7: short and long bursts into bank 3
        open_win(); send_data(20, 0); close_win();
        chk("R7 short burst keeps old tail", pack());
        open_win(); send_data(60, 2); close_win();
        chk("R7 long burst keeps last 50", pack());

        // R2: short mode word 0010 + "10" -> 1010 (all banks)
        open_win(); put_bit(1'b1, 1'b1); put_bit(1'b1, 1'b0); send_data(30, 1); close_win();
        chk("R2 short mode word", pack());
        // R2: long mode word 111000 -> last four 1000 (bank0)
        open_win(); put_bit(1'b1, 1'b1); put_bit(1'b1, 1'b1); send_mode(4'b1000);
        send_data(50, 0); close_win();
        chk("R2 long mode word", pack());

        // R4: full 200-bit chain
        open_win(); send_mode(4'b1010); put_bit(1'b0, 1'b1); send_data(198, 0);
        put_bit(1'b0, 1'b1); close_win();
        chk("R4 all-bank chain", pack());
        chk_bit("R4 first bit at 0", 0, 1'b1);
        chk_bit("R4 last bit at 199", TOT - 1, 1'b1);

        // R1: shift clock while select is low changes nothing
        msel = 1'b0;
        for (int i = 0; i < 8; i++) put_bit(1'b0, 1'b1);
        open_win(); close_win();
        chk("R1 clock with select low ignored", pack());

        // R5: clear, selection (all) kept
        open_win(); send_mode(4'b1111); close_win();
        chk("R5 clear zeroes image", '0);
        open_win(); send_data(10, 0); close_win();
        chk("R5 selection kept after clear", pack());

        // R10: unknown code deselects
        open_win(); send_mode(4'b0001); close_win();
        open_win(); send_data(40, 0); close_win();
        chk("R10 unknown code deselects", pack());

        tick(10);
        $display("[TB] %0d tests run, %0d failed", n_run + clk_run, n_fail + clk_fail);
        $finish;
    end

endmodule